// File: doc/BRIEF.md
# Full-Duplex Serial Port FIFO Front-End

This block connects a 32-bit register bus to a byte-oriented, full-duplex synchronous serial link. A word write to the data location takes the low halfword and places it in an eight-entry transmit queue. A read of the same location takes the oldest halfword from an eight-entry receive queue. Each queue entry holds two bytes. The serial engine sends the low byte of an entry first and then the high byte. It assembles incoming bytes into halfwords in the same order. Software decides how its byte stream is packed into each pair.

The engine has two modes. In master mode it generates the serial clock and a frame strobe from the system clock, and it sends one 16-bit frame per queued entry. In slave mode it follows an external clock and frame strobe, both passed through two-flop synchronizers. A frame in slave mode may end after an odd number of bytes. The last byte then stays parked in the engine, and two status outputs report it. A write of any value to a separate pop location moves the parked byte into the receive queue so that software can read it.

Top module: `ssp_frontend`

## Requirements
- R1: A write to the data location (address 0x0) pushes bus bits [15:0] into the transmit queue and discards bits [31:16]. In master mode an idle engine begins a frame on the next cycle that the queue holds an entry.
- R2: A read of the data location returns the oldest receive entry in bits [15:0] and removes it from the queue. Bits [31:16] read as zero. When the queue is empty the whole word reads as zero.
- R3: Each entry is sent as its bits [7:0] followed by its bits [15:8], with each byte sent MSB first. A new bit appears on the falling serial clock edge.
- R4: Incoming bits are sampled on the rising serial clock edge. The first byte completed forms bits [7:0] of a receive entry, and the second byte completes the entry as bits [15:8].
- R5: In master mode the serial clock idles low and toggles every cfg_half_div system cycles. frame_out stays high for exactly 32*cfg_half_div cycles per entry, which covers 16 rising edges. In slave mode frame_out and sclk_out stay low.
- R6: Each queue holds 8 entries. Its full and empty outputs reflect the current occupancy.
- R7: A data write while the transmit queue is full is dropped. It sets tx_ovf, which then stays set until reset.
- R8: In slave mode the engine follows the synchronized frame_in and sclk_in. At the start of each frame it loads the next transmit entry, and it loads another entry after every 16 falling edges.
- R9: res_frame is high while a single byte is parked. res_valid sets when a frame ends with a byte parked.
- R10: A write to the pop location (address 0x8) ignores its data. If a byte is parked, the write pushes {8'h00, byte} into the receive queue. The write clears res_valid and res_frame in every case. With nothing parked, it leaves the receive queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, receive queue head |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_half_div | input | 8 | Master half-period in system cycles, minimum 1 |
| sclk_in | input | 1 | External serial clock used in slave mode |
| frame_in | input | 1 | External frame strobe used in slave mode |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated serial clock in master mode |
| frame_out | output | 1 | Generated frame strobe in master mode |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| res_valid | output | 1 | A frame ended with a residual byte parked |
| res_frame | output | 1 | A single byte is parked in the engine |

## Verification
The bench builds the block with its default queue depth of 8 and a master half-period of 3 cycles. It links sdo back to sdi in master mode, so every table entry makes a full round trip of 96 cycles. The bench checks bit order, frame length and halfword reassembly on each of these trips. With a queue depth of 8, the bench can fill the transmit queue in a few writes while slave mode holds the engine still, which brings the overflow write within reach. A 24-bit slave frame then checks the entry reload after 16 bits, the residual status and both the loaded and empty cases of the pop write.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int BUS_W   = 32;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 4;

    localparam logic [ADDR_W-1:0] LOC_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] LOC_POP  = 4'h8;

    typedef enum logic {
        M_IDLE,
        M_RUN
    } mstate_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } pair_t;

    // Order on the wire: low byte leaves first, MSB of each byte first.
    function automatic logic [HALF_W-1:0] wire_order(input pair_t p);
        return {p.lo, p.hi};
    endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW:0] FULL_CNT = DEPTH[PW:0];

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [PW:0]      count;
    logic             do_wr, do_rd;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              tx_avail,
    input  logic [HALF_W-1:0] tx_word,
    output logic              tx_take,
    input  logic              sclk_in,
    input  logic              frame_in,
    input  logic              sdi,
    input  logic              flush,
    output logic              rx_push,
    output logic [HALF_W-1:0] rx_word,
    output logic              frame_end,
    output logic              lo_held,
    output logic [BYTE_W-1:0] lo_byte,
    output logic              sclk_out,
    output logic              frame_out,
    output logic              sdo,
    output logic              busy
);
    localparam int SYNC_N = 2;

    // ---------------- slave-side synchronizers ----------------
    logic [SYNC_N-1:0] sclk_q, frm_q, sdi_q;
    logic              sclk_p, frm_p;
    logic              s_rise, s_fall, s_start, s_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            frm_q  <= '0;
            sdi_q  <= '0;
            sclk_p <= 1'b0;
            frm_p  <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[SYNC_N-2:0], sclk_in};
            frm_q  <= {frm_q[SYNC_N-2:0], frame_in};
            sdi_q  <= {sdi_q[SYNC_N-2:0], sdi};
            sclk_p <= sclk_q[SYNC_N-1];
            frm_p  <= frm_q[SYNC_N-1];
        end
    end

    assign s_rise  =  sclk_q[SYNC_N-1] && !sclk_p;
    assign s_fall  = !sclk_q[SYNC_N-1] &&  sclk_p;
    assign s_start =  frm_q[SYNC_N-1]  && !frm_p;
    assign s_end   = !frm_q[SYNC_N-1]  &&  frm_p;

    // ---------------- master clock generator ----------------
    mstate_e           m_state;
    logic [DIV_W-1:0]  m_cnt;
    logic              m_sclk, m_frame;
    logic [3:0]        m_bits;
    logic              m_tick, m_start, m_rise, m_fall, m_last;

    assign m_tick  = (m_state == M_RUN) && (m_cnt == half_div - 1'b1);
    assign m_start = master && (m_state == M_IDLE) && tx_avail;
    assign m_rise  = m_tick && !m_sclk;
    assign m_fall  = m_tick &&  m_sclk;
    assign m_last  = m_fall && (m_bits == 4'd15);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_state <= M_IDLE;
            m_cnt   <= '0;
            m_sclk  <= 1'b0;
            m_frame <= 1'b0;
            m_bits  <= '0;
        end else begin
            case (m_state)
                M_IDLE: begin
                    if (m_start) begin
                        m_state <= M_RUN;
                        m_cnt   <= '0;
                        m_sclk  <= 1'b0;
                        m_frame <= 1'b1;
                        m_bits  <= '0;
                    end
                end
                default: begin
                    if (m_tick) begin
                        m_cnt  <= '0;
                        m_sclk <= !m_sclk;
                        if (m_fall) m_bits <= m_bits + 1'b1;
                        if (m_last) begin
                            m_state <= M_IDLE;
                            m_frame <= 1'b0;
                        end
                    end else begin
                        m_cnt <= m_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- unified bit events ----------------
    logic ev_start, ev_end, ev_rise, ev_fall, bit_in;

    assign ev_start = master ? m_start : s_start;
    assign ev_end   = master ? m_last  : s_end;
    assign ev_rise  = master ? m_rise  : (frm_q[SYNC_N-1] && s_rise);
    assign ev_fall  = master ? m_fall  : (frm_q[SYNC_N-1] && s_fall);
    assign bit_in   = master ? sdi     : sdi_q[SYNC_N-1];

    // ---------------- transmit shifter ----------------
    logic [HALF_W-1:0] tx_sh;
    logic [3:0]        tx_cnt;
    logic              reload;
    logic [HALF_W-1:0] load_val;

    assign reload   = ev_start || (!master && ev_fall && (tx_cnt == 4'd15));
    assign tx_take  = reload && tx_avail;
    assign load_val = tx_avail ? wire_order(pair_t'(tx_word)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh  <= '0;
            tx_cnt <= '0;
        end else if (reload) begin
            tx_sh  <= load_val;
            tx_cnt <= '0;
        end else if (ev_fall) begin
            tx_sh  <= {tx_sh[HALF_W-2:0], 1'b0};
            tx_cnt <= tx_cnt + 1'b1;
        end
    end

    // ---------------- receive assembler ----------------
    logic [BYTE_W-2:0] rx_sh;
    logic [2:0]        rx_cnt;
    logic [BYTE_W-1:0] new_byte;
    logic              byte_done;
    logic [BYTE_W-1:0] lo_q;
    logic              held_q;

    assign new_byte  = {rx_sh, bit_in};
    assign byte_done = ev_rise && (rx_cnt == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh  <= '0;
            rx_cnt <= '0;
            lo_q   <= '0;
            held_q <= 1'b0;
        end else begin
            if (ev_start) begin
                rx_cnt <= '0;
            end else if (ev_rise) begin
                rx_sh  <= new_byte[BYTE_W-2:0];
                rx_cnt <= rx_cnt + 1'b1;
            end
            if (byte_done) begin
                if (held_q) begin
                    held_q <= 1'b0;
                end else begin
                    lo_q   <= new_byte;
                    held_q <= 1'b1;
                end
            end else if (flush) begin
                held_q <= 1'b0;
            end
        end
    end

    assign rx_push   = byte_done && held_q;
    assign rx_word   = {new_byte, lo_q};
    assign frame_end = ev_end;
    assign lo_held   = held_q;
    assign lo_byte   = lo_q;
    assign sclk_out  = m_sclk;
    assign frame_out = m_frame;
    assign sdo       = tx_sh[HALF_W-1];
    assign busy      = master ? (m_state == M_RUN) : frm_q[SYNC_N-1];
endmodule

// File: rtl/ssp_frontend.sv
module ssp_frontend
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cfg_master,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              sclk_in,
    input  logic              frame_in,
    input  logic              sdi,
    output logic              sclk_out,
    output logic              frame_out,
    output logic              sdo,
    output logic              busy,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              tx_ovf,
    output logic              res_valid,
    output logic              res_frame
);
    logic sel_data, sel_pop, tx_wr, rx_rd, pop_wr;
    logic unused_upper;

    assign sel_data     = (bus_addr == LOC_DATA);
    assign sel_pop      = (bus_addr == LOC_POP);
    assign tx_wr        = bus_wr && sel_data;
    assign rx_rd        = bus_rd && sel_data;
    assign pop_wr       = bus_wr && sel_pop;
    assign unused_upper = ^bus_wdata[BUS_W-1:HALF_W];

    logic [HALF_W-1:0] tx_head, rx_head, eng_rx_word, rx_din;
    logic              tx_take, eng_push, frame_end, held;
    logic [BYTE_W-1:0] held_byte;
    logic              rx_wr;

    ssp_fifo #(.WIDTH(HALF_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .wr_en (tx_wr),
        .din   (bus_wdata[HALF_W-1:0]),
        .rd_en (tx_take),
        .dout  (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign rx_wr  = eng_push || (pop_wr && held);
    assign rx_din = eng_push ? eng_rx_word : {{BYTE_W{1'b0}}, held_byte};

    ssp_fifo #(.WIDTH(HALF_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .wr_en (rx_wr),
        .din   (rx_din),
        .rd_en (rx_rd),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    ssp_engine #(.DIV_W(DIV_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .master    (cfg_master),
        .half_div  (cfg_half_div),
        .tx_avail  (!tx_empty),
        .tx_word   (tx_head),
        .tx_take   (tx_take),
        .sclk_in   (sclk_in),
        .frame_in  (frame_in),
        .sdi       (sdi),
        .flush     (pop_wr),
        .rx_push   (eng_push),
        .rx_word   (eng_rx_word),
        .frame_end (frame_end),
        .lo_held   (held),
        .lo_byte   (held_byte),
        .sclk_out  (sclk_out),
        .frame_out (frame_out),
        .sdo       (sdo),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf    <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            if (tx_wr && tx_full) tx_ovf <= 1'b1;
            if (pop_wr)                 res_valid <= 1'b0;
            else if (frame_end && held) res_valid <= 1'b1;
        end
    end

    assign res_frame = held;
    assign bus_rdata = rx_empty ? '0 : {{(BUS_W-HALF_W){1'b0}}, rx_head};
endmodule

// File: rtl/ssp_frontend_chk.sv
module ssp_frontend_chk
    import ssp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              cfg_master,
    input logic              sclk_out,
    input logic              frame_out,
    input logic              busy,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              tx_ovf,
    input logic              res_valid,
    input logic              res_frame
);
    // R7
    full_write_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == LOC_DATA && tx_full) |=> tx_ovf);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ovf |=> tx_ovf);

    // R9
    res_valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $past(res_frame));

    // R10
    pop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == LOC_POP && !busy) |=> (!res_valid && !res_frame));

    // R5
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_out |-> !sclk_out);

    // R5
    slave_frame_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_master && !frame_out) |=> !frame_out);

    // R6
    queue_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

bind ssp_frontend ssp_frontend_chk u_chk (.*);

// File: tb/ssp_frontend_tb.sv
module ssp_frontend_tb;
    import ssp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_master = 1'b1;
    logic [7:0]  cfg_half_div = 8'd3;
    logic        sclk_in = 1'b0, frame_in = 1'b0, s_sdi = 1'b0;
    logic        sdi;
    logic        sclk_out, frame_out, sdo, busy;
    logic        tx_full, tx_empty, rx_full, rx_empty, tx_ovf, res_valid, res_frame;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign sdi = cfg_master ? sdo : s_sdi;

    ssp_frontend u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_master(cfg_master),
        .cfg_half_div(cfg_half_div), .sclk_in(sclk_in), .frame_in(frame_in), .sdi(sdi),
        .sclk_out(sclk_out), .frame_out(frame_out), .sdo(sdo), .busy(busy),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_ovf(tx_ovf), .res_valid(res_valid), .res_frame(res_frame)
    );

    // Master-side wire monitor
    logic        prev_sclk = 1'b0, prev_frame = 1'b0;
    logic [15:0] cap = '0;
    int          rises = 0, flen = 0;

    always @(posedge clk) begin
        prev_sclk  <= sclk_out;
        prev_frame <= frame_out;
        if (frame_out && !prev_frame) begin
            flen  <= 1;
            rises <= 0;
        end else if (frame_out) begin
            flen <= flen + 1;
            if (sclk_out && !prev_sclk) begin
                cap   <= {cap[14:0], sdo};
                rises <= rises + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(output logic [31:0] d);
        @(negedge clk);
        bus_addr = LOC_DATA; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tx_empty && !busy && !frame_out) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic slave_bit(input logic b, output logic seen);
        s_sdi = b;
        repeat (8) @(negedge clk);
        seen = sdo;
        sclk_in = 1'b1;
        repeat (8) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    // {write word, expected halfword}
    localparam logic [47:0] VECS [0:5] = '{
        {32'h0000_A5C3, 16'hA5C3},
        {32'hDEAD_1234, 16'h1234},
        {32'hFFFF_0000, 16'h0000},
        {32'h0000_FFFF, 16'hFFFF},
        {32'h1234_8001, 16'h8001},
        {32'h5555_00FF, 16'h00FF}
    };

    initial begin
        logic [31:0] rd;
        logic [23:0] s_in, s_out;
        logic        seen;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R6, R7, R9, R5)
        chk("R6 tx_empty after reset", {31'b0, tx_empty}, 32'd1);
        chk("R6 rx_empty after reset", {31'b0, rx_empty}, 32'd1);
        chk("R7 tx_ovf after reset", {31'b0, tx_ovf}, 32'd0);
        chk("R9 res flags after reset", {30'b0, res_valid, res_frame}, 32'd0);
        chk("R5 frame_out after reset", {31'b0, frame_out}, 32'd0);
        chk("R2 empty read is zero", bus_rdata, 32'd0);

        // Master loopback walk (R1..R5)
        foreach (VECS[k]) begin
            bus_write(LOC_DATA, VECS[k][47:16]);
            wait_idle();
            chk("R5 frame length", flen, 32'd96);
            chk("R5 rising edges per frame", rises, 32'd16);
            chk("R3 wire order", {16'h0, cap}, {16'h0, VECS[k][7:0], VECS[k][15:8]});
            bus_read(rd);
            chk("R1 R2 R4 loopback halfword", rd, {16'h0, VECS[k][15:0]});
        end
        chk("R2 queue empty after reads", {31'b0, rx_empty}, 32'd1);

        // Fill the transmit queue in slave mode (R6, R7)
        cfg_master = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) bus_write(LOC_DATA, 32'h0000_1100 + i);
        chk("R6 tx_full after 8 writes", {31'b0, tx_full}, 32'd1);
        chk("R7 no overflow yet", {31'b0, tx_ovf}, 32'd0);
        bus_write(LOC_DATA, 32'h0000_BEEF);
        chk("R7 overflow on full write", {31'b0, tx_ovf}, 32'd1);
        chk("R5 slave mode frame_out low", {31'b0, frame_out}, 32'd0);

        // Slave frame of 3 bytes (R8, R4, R9)
        s_in = {8'h3C, 8'h5A, 8'h96};
        frame_in = 1'b1;
        repeat (8) @(negedge clk);
        for (int b = 23; b >= 0; b--) begin
            slave_bit(s_in[b], seen);
            s_out[b] = seen;
        end
        repeat (4) @(negedge clk);
        chk("R9 res_frame mid frame", {31'b0, res_frame}, 32'd1);
        chk("R9 res_valid before frame end", {31'b0, res_valid}, 32'd0);
        frame_in = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 R3 first entry on wire", {16'h0, s_out[23:8]}, 32'h0000_0011);
        chk("R8 reload after 16 bits", {24'h0, s_out[7:0]}, 32'h0000_0001);
        chk("R6 tx_full cleared by two loads", {31'b0, tx_full}, 32'd0);
        chk("R9 res_valid at frame end", {31'b0, res_valid}, 32'd1);
        bus_read(rd);
        chk("R4 R8 slave halfword", rd, 32'h0000_5A3C);
        chk("R2 rx empty before pop", {31'b0, rx_empty}, 32'd1);

        // Pop residual (R10)
        bus_write(LOC_POP, 32'hFFFF_FFFF);
        chk("R10 flags cleared by pop", {30'b0, res_valid, res_frame}, 32'd0);
        chk("R10 pop pushed entry", {31'b0, rx_empty}, 32'd0);
        bus_read(rd);
        chk("R10 residual value", rd, 32'h0000_0096);
        bus_write(LOC_POP, 32'h0000_1234);
        chk("R10 empty pop adds nothing", {31'b0, rx_empty}, 32'd1);
        chk("R7 overflow still set", {31'b0, tx_ovf}, 32'd1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule